// File: doc/BRIEF.md
# System Control Register File

This block holds the thirty-two control registers of a processor's system coprocessor. Each register is reached by a 5-bit register number plus a 3-bit select. Software writes do not land directly in storage. Each write passes through a per-register pair of masks: one keeps the bits that are read-only and the other admits the bits that software may change. A few status flags (user mode, exception level, error level and debug mode) are held outside the masked words and are merged back in when their register is read. Hardware interrupt lines appear live in the cause register, and the lock address register reads back shifted down by four.

Reads and writes are both synchronous. A read request is captured at a clock edge and its data is valid after that edge. The data stays unchanged until the next read request. A read issued in the same cycle as a write returns the value from before the write.

The block also drives a hard-interrupt request. The request rises when software turns the global interrupt enable on while an unmasked interrupt is already pending. It falls when software turns the enable off. Timers, translation entries and exception entry are handled elsewhere.

Top module: `scp_regfile`

## Requirements
- R1: After reset every register reads zero, except register 15, which reads the PRID_VALUE parameter, and register 16 select 1, which reads the CFG1_VALUE parameter. irq_req is low after reset. Writes to register 15 have no effect.
- R2: A write to register 0 keeps the stored bit 31 and takes only bits 3:0 of the data. Writing 0xFFFFFFFF after reset reads back as 0x0000000F.
- R3: Write masks: registers 2 and 3 use 0x3FFFFFFF, register 5 uses 0x01FFE000, register 6 uses 0x0000000F, and register 10 uses 0xFFFFF0FF.
- R4: A write to register 4 keeps the stored bits 31:24 and takes bits 23:4 of the data.
- R5: A write to register 12 stores the data masked with 0xFA78FF01. Data bits 1, 2 and 4 are latched as separate flags, and a read of register 12 ORs those flags back into bits 1, 2 and 4.
- R6: A write to register 13 changes only bits 9:8. A read of register 13 shows the irq_lines input live in bits 15:10.
- R7: irq_req is set at the edge of a register 12 write when all of these hold: data bit 0 is 1, the old bit 0 is 0, data bits 1 and 2 are 0, the debug-mode flag is clear, and (data & 0xFA78FF01) & cause & 0x0000FF00 is nonzero. The cause value includes the live lines. irq_req is never set in any other way.
- R8: A register 12 write that changes bit 0 from 1 to 0 clears irq_req. Every other write leaves irq_req unchanged.
- R9: Further write masks: register 19 uses 0x40FF0FF8, and register 28 select 0 uses 0xFFFFFCF6. A write to register 23 keeps the stored bits under 0x8C03FC1F and takes the data bits under 0x13300120. Data bit 30 of a register 23 write sets the debug-mode flag, which reads back in bit 30. Register 16 select 0 keeps the stored bits under 0xFE17FF80 and takes data bit 0.
- R10: Register 17 accepts any data, and a read of it returns the stored value shifted right by 4.
- R11: Any write with a nonzero select is ignored. A read with a nonzero select returns zero, except register 16 select 1 (CFG1_VALUE). Register 28 select 1 reads zero.
- R12: Register numbers with no storage (1, 7, 9, 11, 20 to 22, 25 to 27, 29) ignore writes and read as zero. Register 8 is read-only and reads zero.
- R13: rd_data updates only at an edge where rd_en is high and holds otherwise. A read and a write issued in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request |
| wr_num | input | 5 | Write register number |
| wr_sel | input | 3 | Write select |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read request |
| rd_num | input | 5 | Read register number |
| rd_sel | input | 3 | Read select |
| rd_data | output | 32 | Registered read data |
| irq_lines | input | 6 | Hardware interrupt lines, shown in cause bits 15:10 |
| irq_req | output | 1 | Hard-interrupt request |

## Verification
The assertions watch several properties on every cycle:
- irq_req only rises after an enabling status write.
- irq_req falls after a disabling status write.
- irq_req never rises while an exception flag or debug mode blocks it.
- rd_data holds when no read is requested.
- Writes with a nonzero select reach no storage.
- Lock-address reads always have a zero top nibble.

Only the bench scenarios can show the exact masked values, the flag merge on reads, and the live interrupt lines. The same holds for the software and hardware interrupt patterns and for read-before-write ordering.

// File: rtl/scp_pkg.sv
package scp_pkg;

   localparam int unsigned RN_INDEX  = 0;
   localparam int unsigned RN_STATUS = 12;
   localparam int unsigned RN_CAUSE  = 13;
   localparam int unsigned RN_PRID   = 15;
   localparam int unsigned RN_CONFIG = 16;
   localparam int unsigned RN_LLADDR = 17;
   localparam int unsigned RN_DEBUG  = 23;
   localparam int unsigned RN_TAG    = 28;

   localparam int unsigned BIT_IE  = 0;
   localparam int unsigned BIT_EXL = 1;
   localparam int unsigned BIT_ERL = 2;
   localparam int unsigned BIT_UM  = 4;
   localparam int unsigned BIT_DM  = 30;
   localparam int unsigned IP_LSB  = 10;

   localparam logic [31:0] STATUS_TAKE = 32'hFA78_FF01;
   localparam logic [31:0] IM_FIELD    = 32'h0000_FF00;

   typedef struct packed {
      logic        wr_ok;
      logic [31:0] keep;
      logic [31:0] take;
   } wmask_t;

   function automatic wmask_t wmask_of(int unsigned n);
      wmask_t m;
      m = '{wr_ok: 1'b1, keep: 32'h0, take: 32'h0};
      case (n)
         0:  begin m.keep = 32'h8000_0000; m.take = 32'h0000_000F; end
         2, 3: m.take = 32'h3FFF_FFFF;
         4:  begin m.keep = 32'hFF00_0000; m.take = 32'h00FF_FFF0; end
         5:  m.take = 32'h01FF_E000;
         6:  m.take = 32'h0000_000F;
         10: m.take = 32'hFFFF_F0FF;
         12: m.take = STATUS_TAKE;
         13: begin m.keep = 32'hB000_F87C; m.take = 32'h0000_0300; end
         14, 17, 18, 24, 30, 31: m.take = 32'hFFFF_FFFF;
         16: begin m.keep = 32'hFE17_FF80; m.take = 32'h0000_0001; end
         19: m.take = 32'h40FF_0FF8;
         23: begin m.keep = 32'h8C03_FC1F; m.take = 32'h1330_0120; end
         28: m.take = 32'hFFFF_FCF6;
         default: m.wr_ok = 1'b0;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/scp_wr_decode.sv
module scp_wr_decode
   import scp_pkg::*;
#(
   parameter int NUM_REGS = 32,
   parameter int SEL_W    = 3,
   localparam int AW      = $clog2(NUM_REGS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [AW-1:0]       wr_num,
   input  logic [SEL_W-1:0]    wr_sel,
   output logic [NUM_REGS-1:0] wr_hit
);

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
      localparam wmask_t M = wmask_of(i);
      if (M.wr_ok) begin : g_wr
         assign wr_hit[i] = wr_en && (wr_num == AW'(i)) && (wr_sel == '0);
      end else begin : g_ro
         assign wr_hit[i] = 1'b0;
      end
   end

   p_sel_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel != '0) |-> (wr_hit == '0));
   p_single_hit_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_hit));

endmodule

// File: rtl/scp_irq_ctrl.sv
module scp_irq_ctrl
   import scp_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_wr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] status_old,
   input  logic [DATA_W-1:0] cause_live,
   input  logic              dm_flag,
   output logic              irq_req
);

   logic [DATA_W-1:0] status_new;
   logic              pending, blocked, raise, drop;

   always_comb begin
      status_new = wr_data & STATUS_TAKE;
      pending    = |(status_new & cause_live & IM_FIELD);
      blocked    = wr_data[BIT_EXL] | wr_data[BIT_ERL] | dm_flag;
      raise      = st_wr && wr_data[BIT_IE] && !status_old[BIT_IE] && !blocked && pending;
      drop       = st_wr && !wr_data[BIT_IE] && status_old[BIT_IE];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     irq_req <= 1'b0;
      else if (raise) irq_req <= 1'b1;
      else if (drop)  irq_req <= 1'b0;
   end

   p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req) |-> $past(st_wr));
   p_irq_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr && (wr_data[BIT_EXL] || wr_data[BIT_ERL] || dm_flag) && !irq_req) |=> !irq_req);
   p_irq_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr && !wr_data[BIT_IE] && status_old[BIT_IE]) |=> !irq_req);

endmodule

// File: rtl/scp_rd_port.sv
module scp_rd_port
   import scp_pkg::*;
#(
   parameter int          NUM_REGS   = 32,
   parameter int          DATA_W     = 32,
   parameter int          SEL_W      = 3,
   parameter logic [31:0] CFG1_VALUE = 32'h0,
   localparam int         AW         = $clog2(NUM_REGS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       rd_en,
   input  logic [AW-1:0]              rd_num,
   input  logic [SEL_W-1:0]           rd_sel,
   input  logic [NUM_REGS*DATA_W-1:0] regs_flat,
   input  logic [DATA_W-1:0]          cause_live,
   input  logic                       flag_um,
   input  logic                       flag_erl,
   input  logic                       flag_exl,
   input  logic                       flag_dm,
   output logic [DATA_W-1:0]          rd_data
);

   logic [DATA_W-1:0] raw, merged;

   assign raw = regs_flat[rd_num*DATA_W +: DATA_W];

   always_comb begin
      merged = '0;
      if (rd_sel == '0) begin
         merged = raw;
         case (32'(rd_num))
            RN_STATUS: begin
               merged[BIT_UM]  = raw[BIT_UM]  | flag_um;
               merged[BIT_ERL] = raw[BIT_ERL] | flag_erl;
               merged[BIT_EXL] = raw[BIT_EXL] | flag_exl;
            end
            RN_CAUSE:  merged = cause_live;
            RN_LLADDR: merged = raw >> 4;
            RN_DEBUG:  merged[BIT_DM] = raw[BIT_DM] | flag_dm;
            default: ;
         endcase
      end else if (rd_sel == SEL_W'(1) && 32'(rd_num) == RN_CONFIG) begin
         merged = CFG1_VALUE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= merged;
   end

   p_rd_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));
   p_lladdr_top_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_sel == '0 && 32'(rd_num) == RN_LLADDR) |=> (rd_data[DATA_W-1 -: 4] == 4'h0));
   p_badsel_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_sel != '0 && !(rd_sel == SEL_W'(1) && 32'(rd_num) == RN_CONFIG))
      |=> (rd_data == '0));

endmodule

// File: rtl/scp_regfile.sv
module scp_regfile
   import scp_pkg::*;
#(
   parameter int          NUM_REGS   = 32,
   parameter int          DATA_W     = 32,
   parameter int          SEL_W      = 3,
   parameter int          IRQ_LINES  = 6,
   parameter logic [31:0] PRID_VALUE = 32'h0001_8000,
   parameter logic [31:0] CFG1_VALUE = 32'h1E19_0C8A,
   localparam int         AW         = $clog2(NUM_REGS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [AW-1:0]        wr_num,
   input  logic [SEL_W-1:0]     wr_sel,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic                 rd_en,
   input  logic [AW-1:0]        rd_num,
   input  logic [SEL_W-1:0]     rd_sel,
   output logic [DATA_W-1:0]    rd_data,
   input  logic [IRQ_LINES-1:0] irq_lines,
   output logic                 irq_req
);

   if (DATA_W != 32) begin : g_chk_w
      $error("scp_regfile: masks are defined for 32-bit registers only");
   end
   if (NUM_REGS != 32) begin : g_chk_n
      $error("scp_regfile: register map expects 32 entries");
   end
   if (IRQ_LINES < 1 || IRQ_LINES > 6) begin : g_chk_irq
      $error("scp_regfile: IRQ_LINES must be 1..6");
   end

   logic [NUM_REGS-1:0]        wr_hit;
   logic [DATA_W-1:0]          reg_q [NUM_REGS];
   logic [NUM_REGS*DATA_W-1:0] regs_flat;
   logic                       flag_um, flag_erl, flag_exl, flag_dm;
   logic [DATA_W-1:0]          cause_live;

   scp_wr_decode #(.NUM_REGS(NUM_REGS), .SEL_W(SEL_W)) i_dec (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_num(wr_num),
      .wr_sel(wr_sel), .wr_hit(wr_hit));

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      localparam wmask_t M = wmask_of(i);
      if (M.wr_ok) begin : g_rw
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk) begin
            if (!rst_n)         q <= '0;
            else if (wr_hit[i]) q <= (q & M.keep) | (wr_data & M.take);
         end
         assign reg_q[i] = q;
      end else if (i == RN_PRID) begin : g_id
         assign reg_q[i] = PRID_VALUE;
      end else begin : g_none
         assign reg_q[i] = '0;
      end
      assign regs_flat[i*DATA_W +: DATA_W] = reg_q[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_um  <= 1'b0;
         flag_erl <= 1'b0;
         flag_exl <= 1'b0;
         flag_dm  <= 1'b0;
      end else begin
         if (wr_hit[RN_STATUS]) begin
            flag_um  <= wr_data[BIT_UM];
            flag_erl <= wr_data[BIT_ERL];
            flag_exl <= wr_data[BIT_EXL];
         end
         if (wr_hit[RN_DEBUG]) flag_dm <= wr_data[BIT_DM];
      end
   end

   always_comb begin
      cause_live = reg_q[RN_CAUSE];
      cause_live[IP_LSB +: IRQ_LINES] = reg_q[RN_CAUSE][IP_LSB +: IRQ_LINES] | irq_lines;
   end

   scp_irq_ctrl #(.DATA_W(DATA_W)) i_irq (
      .clk(clk), .rst_n(rst_n), .st_wr(wr_hit[RN_STATUS]), .wr_data(wr_data),
      .status_old(reg_q[RN_STATUS]), .cause_live(cause_live),
      .dm_flag(flag_dm), .irq_req(irq_req));

   scp_rd_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .SEL_W(SEL_W),
                 .CFG1_VALUE(CFG1_VALUE)) i_rd (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_num(rd_num), .rd_sel(rd_sel),
      .regs_flat(regs_flat), .cause_live(cause_live), .flag_um(flag_um),
      .flag_erl(flag_erl), .flag_exl(flag_exl), .flag_dm(flag_dm),
      .rd_data(rd_data));

   p_prid_wr_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit[RN_PRID]);

endmodule

// File: tb/test_scp_regfile.sv
`timescale 1ns/1ps
module test_scp_regfile;

   localparam logic [31:0] PRID = 32'h0001_8000;
   localparam logic [31:0] CFG1 = 32'h1E19_0C8A;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_num = '0;
   logic [2:0]  wr_sel = '0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [4:0]  rd_num = '0;
   logic [2:0]  rd_sel = '0;
   logic [31:0] rd_data;
   logic [5:0]  irq_lines = '0;
   logic        irq_req;

   int errors = 0;
   int checks = 0;
   logic [31:0] exp_q [$];
   string       tag_q [$];

   always #2 clk = ~clk;

   scp_regfile #(.PRID_VALUE(PRID), .CFG1_VALUE(CFG1)) i_scp_regfile (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_num(wr_num), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_en(rd_en), .rd_num(rd_num), .rd_sel(rd_sel),
      .rd_data(rd_data), .irq_lines(irq_lines), .irq_req(irq_req));

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   // monitor: pops the scoreboard one time unit after each capturing edge
   always @(posedge clk) begin
      if (rst_n && rd_en) begin
         #1;
         if (exp_q.size() == 0) check("R13 unexpected read", 32'h0, 32'h1);
         else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
   end

   task automatic wr(input logic [4:0] n, input logic [2:0] s, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_num = n; wr_sel = s; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [4:0] n, input logic [2:0] s,
                     input logic [31:0] exp, input string tag);
      @(negedge clk);
      exp_q.push_back(exp); tag_q.push_back(tag);
      rd_en = 1'b1; rd_num = n; rd_sel = s;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic irq_is(logic exp, string tag);
      check(tag, {31'b0, irq_req}, {31'b0, exp});
   endtask

   initial begin
      #(4 * 50000);
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      irq_is(1'b0, "R1 irq after reset");
      rd(15, 0, PRID, "R1 prid");
      rd(12, 0, 32'h0, "R1 status zero");
      rd(16, 1, CFG1, "R1 config1");
      wr(15, 0, 32'hFFFF_FFFF);
      rd(15, 0, PRID, "R1 prid unwritable");
      // R2 / R3 / R4
      wr(0, 0, 32'hFFFF_FFFF);  rd(0, 0, 32'h0000_000F, "R2 index");
      wr(2, 0, 32'hFFFF_FFFF);  rd(2, 0, 32'h3FFF_FFFF, "R3 entrylo0");
      wr(3, 0, 32'hFFFF_FFFF);  rd(3, 0, 32'h3FFF_FFFF, "R3 entrylo1");
      wr(5, 0, 32'hFFFF_FFFF);  rd(5, 0, 32'h01FF_E000, "R3 pagemask");
      wr(6, 0, 32'hFFFF_FFFF);  rd(6, 0, 32'h0000_000F, "R3 wired");
      wr(10, 0, 32'hFFFF_FFFF); rd(10, 0, 32'hFFFF_F0FF, "R3 entryhi");
      wr(4, 0, 32'hFFFF_FFFF);  rd(4, 0, 32'h00FF_FFF0, "R4 context");
      // R5 status mask and flag merge; EXL set so no interrupt
      wr(12, 0, 32'hFFFF_FFFF); rd(12, 0, 32'hFA78_FF17, "R5 status all ones");
      irq_is(1'b0, "R7 exl blocks");
      wr(12, 0, 32'h0);         rd(12, 0, 32'h0, "R5 status cleared");
      // R6 cause
      wr(13, 0, 32'hFFFF_FFFF); rd(13, 0, 32'h0000_0300, "R6 cause sw bits");
      irq_lines = 6'b000001;    rd(13, 0, 32'h0000_0700, "R6 cause live line");
      // R7 / R8 hardware interrupt
      wr(12, 0, 32'h0000_0401); irq_is(1'b1, "R7 hw raise");
      wr(12, 0, 32'h0000_0401); irq_is(1'b1, "R8 hold on rewrite");
      wr(12, 0, 32'h0000_0400); irq_is(1'b0, "R8 drop on IE clear");
      // R7 software interrupt via cause bit 8
      wr(12, 0, 32'h0000_0101); irq_is(1'b1, "R7 sw raise");
      wr(12, 0, 32'h0000_0100); irq_is(1'b0, "R8 sw drop");
      // R7 nothing pending
      irq_lines = '0; wr(13, 0, 32'h0);
      wr(12, 0, 32'h0000_0401); irq_is(1'b0, "R7 no pending");
      wr(12, 0, 32'h0);
      // R7 ERL blocks
      irq_lines = 6'b000001;
      wr(12, 0, 32'h0000_0405); irq_is(1'b0, "R7 erl blocks");
      rd(12, 0, 32'h0000_0405, "R5 erl merged");
      wr(12, 0, 32'h0);
      // R9 debug mode blocks
      wr(23, 0, 32'h4000_0000); rd(23, 0, 32'h4000_0000, "R9 dm merged");
      wr(12, 0, 32'h0000_0401); irq_is(1'b0, "R7 dm blocks");
      wr(12, 0, 32'h0);
      wr(23, 0, 32'hFFFF_FFFF); rd(23, 0, 32'h5330_0120, "R9 debug mask");
      wr(23, 0, 32'h0);         rd(23, 0, 32'h0, "R9 debug cleared");
      irq_lines = '0;
      // R9 other masks
      wr(19, 0, 32'hFFFF_FFFF); rd(19, 0, 32'h40FF_0FF8, "R9 watchhi");
      wr(28, 0, 32'hFFFF_FFFF); rd(28, 0, 32'hFFFF_FCF6, "R9 taglo");
      wr(16, 0, 32'hFFFF_FFFF); rd(16, 0, 32'h0000_0001, "R9 config0");
      // R10
      wr(17, 0, 32'h1234_5678); rd(17, 0, 32'h0123_4567, "R10 lladdr shift");
      // R11 selects
      wr(14, 0, 32'h1111_1111);
      wr(14, 2, 32'hFFFF_FFFF); rd(14, 0, 32'h1111_1111, "R11 bad sel write ignored");
      rd(14, 1, 32'h0, "R11 bad sel read zero");
      wr(28, 1, 32'hFFFF_FFFF); rd(28, 1, 32'h0, "R11 datalo");
      rd(28, 0, 32'hFFFF_FCF6, "R11 taglo untouched");
      wr(16, 1, 32'h0);         rd(16, 1, CFG1, "R11 config1 read-only");
      // R12 unmapped
      wr(7, 0, 32'hFFFF_FFFF);  rd(7, 0, 32'h0, "R12 reg7");
      wr(9, 0, 32'hFFFF_FFFF);  rd(9, 0, 32'h0, "R12 reg9");
      wr(8, 0, 32'hFFFF_FFFF);  rd(8, 0, 32'h0, "R12 reg8");
      // R13 read-before-write and hold
      @(negedge clk);
      exp_q.push_back(32'h1111_1111); tag_q.push_back("R13 read before write");
      wr_en = 1'b1; wr_num = 14; wr_sel = 0; wr_data = 32'hABCD_0123;
      rd_en = 1'b1; rd_num = 14; rd_sel = 0;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      wr(14, 0, 32'h0);
      check("R13 hold without read", rd_data, 32'h1111_1111);
      rd(14, 0, 32'h0, "R13 new value");
      repeat (3) @(negedge clk);
      check("R13 scoreboard drained", 32'(exp_q.size()), 32'h0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule